// File: doc/BRIEF.md
# Half-Duplex Command/Response Serial Master

This block is the master end of a half-duplex serial message exchange. A frame opens by pulling an active-low select line low. The master then shifts an 8-bit command to the slave, most significant bit first. One idle serial clock period follows as a turnaround gap. After that gap the slave returns a response word of 4 to 16 bits, and the master shifts it in. Data never moves in both directions at once: the receive line is ignored while the command goes out, and the transmit line is held low while the response comes back.

On the parallel side, a one-cycle start strobe launches a frame using the command byte, response length and clock divisor present on the inputs in that cycle. A busy flag covers the whole exchange. The received word comes back right-justified, qualified by a one-cycle valid strobe. The serial clock is made from the system clock by a divisor chosen per frame. It idles low and runs only while the select line is low.

Top module: `cmdrsp_master`

## Requirements
- R1: After reset, selN is 1, sclk is 0, txd is 0, busy is 0, respValid is 0 and respData is 0.
- R2: In each frame the 8 command bits appear on txd MSB first. Each bit is valid at one of the first 8 rising sclk edges. txd changes only when sclk falls, or at the moment selN falls for the first bit. selN stays 0 from the start of the frame until it ends.
- R3: rxd is not captured during the command phase. Values the slave drives during rising edges 1 to 8 do not reach respData.
- R4: Exactly one serial period separates the command from the response. Rising edge 9 is not a sample point. Response bit k, counted from 0 as the first received bit, is sampled on rising edge 10+k.
- R5: The response length L is taken from respLen when the frame starts. Values below 4 are treated as 4, and values above 16 are treated as 16. A frame has exactly 9+L rising sclk edges. respData holds the L received bits right-justified, with the first received bit in bit L-1 and all higher bits 0.
- R6: sclk is 0 whenever selN is 1 and changes only while selN is 0. Each sclk half period lasts divisor+1 system clock cycles, where divisor is taken when the frame starts.
- R7: txd is 0 during the turnaround period, during the response phase and between frames.
- R8: selN returns to 1 exactly 2*(divisor+1) system clock cycles after the last response sample edge. In that same cycle respValid is 1 for a single cycle and busy falls to 0.
- R9: busy becomes 1 in the cycle after a start strobe is accepted while the block is idle.
- R10: A start strobe that arrives while busy is 1 has no effect. The running frame keeps its command, length and timing, and no extra frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| start | input | 1 | One-cycle request to begin a frame |
| cmdByte | input | 8 | Command sent to the slave |
| respLen | input | 5 | Requested response length in bits |
| divisor | input | 8 | Serial half period minus one, in system clocks |
| busy | output | 1 | High while a frame is in progress |
| respData | output | 16 | Last received response, right-justified |
| respValid | output | 1 | One-cycle strobe when respData is updated |
| sclk | output | 1 | Serial clock, idle low |
| selN | output | 1 | Active-low frame select |
| txd | output | 1 | Serial data to the slave |
| rxd | input | 1 | Serial data from the slave |

## Verification
A wrong period index shows up within one frame at the ports. The number of sclk rising edges between the fall and the rise of selN changes, and respData collects junk from the command or turnaround phase. A faulty divider counter or sample strobe changes the spacing of sclk edges, or the gap from the last sample to deselect, by whole system clock cycles, and this shows on the first edge it touches. A command shift register that fails to clear leaves txd high in the response phase, so the bench's model slave sees it on the very next rising edge.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;
  // strobes from the control sequencer to the shift datapath
  typedef struct packed {
    logic load;      // frame accepted: capture command, clear receive shifter
    logic shiftTx;   // falling serial edge inside the frame: next command bit
    logic sampleRx;  // rising serial edge in the response phase
    logic finish;    // frame ends: publish response
  } ctrlStrobes_t;
endpackage

// File: rtl/cmdrsp_ctrl.sv
module cmdrsp_ctrl
  import cmdrsp_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int CMD_W    = 8,
  parameter int RESP_MIN = 4,
  parameter int RESP_MAX = 16,
  parameter int LEN_W    = $clog2(RESP_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] respLen,
  input  logic [DIV_W-1:0] divisor,
  output logic             busy,
  output logic             sclk,
  output logic             selN,
  output logic             respValid,
  output ctrlStrobes_t     strb
);
  localparam int PER_W = $clog2(CMD_W + RESP_MAX + 2);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} state_t;

  state_t           state;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] halfDivQ;
  logic [LEN_W-1:0] lenQ;
  logic [PER_W-1:0] periodIdx;
  logic             sclkQ;
  logic             selNQ;
  logic             validQ;

  logic             tick;
  logic             lastPeriod;
  logic             inResp;
  logic [LEN_W-1:0] lenClamp;

  always_comb begin
    if (respLen < LEN_W'(RESP_MIN))      lenClamp = LEN_W'(RESP_MIN);
    else if (respLen > LEN_W'(RESP_MAX)) lenClamp = LEN_W'(RESP_MAX);
    else                                 lenClamp = respLen;
  end

  assign tick       = (state != ST_IDLE) && (divCnt == halfDivQ);
  assign lastPeriod = (periodIdx == (PER_W'(CMD_W) + PER_W'(lenQ)));
  assign inResp     = (periodIdx > PER_W'(CMD_W));

  always_comb begin
    strb          = '0;
    strb.load     = (state == ST_IDLE) && start;
    strb.sampleRx = (state == ST_RUN) && tick && !sclkQ && inResp;
    strb.shiftTx  = (state == ST_RUN) && tick && sclkQ && !lastPeriod;
    strb.finish   = (state == ST_TAIL) && tick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      halfDivQ  <= '0;
      lenQ      <= LEN_W'(RESP_MIN);
      periodIdx <= '0;
      sclkQ     <= 1'b0;
      selNQ     <= 1'b1;
      validQ    <= 1'b0;
    end else begin
      validQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_RUN;
            selNQ     <= 1'b0;
            divCnt    <= '0;
            halfDivQ  <= divisor;
            lenQ      <= lenClamp;
            periodIdx <= '0;
            sclkQ     <= 1'b0;
          end
        end
        ST_RUN: begin
          if (tick) begin
            divCnt <= '0;
            if (!sclkQ) begin
              sclkQ <= 1'b1;
            end else begin
              sclkQ <= 1'b0;
              if (lastPeriod) state <= ST_TAIL;
              else            periodIdx <= periodIdx + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            state  <= ST_IDLE;
            selNQ  <= 1'b1;
            validQ <= 1'b1;
            divCnt <= '0;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign sclk      = sclkQ;
  assign selN      = selNQ;
  assign respValid = validQ;

  // checker state: samples taken in the current frame
  logic [LEN_W-1:0] sampleCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sampleCnt <= '0;
    else if (strb.load)     sampleCnt <= '0;
    else if (strb.sampleRx) sampleCnt <= sampleCnt + 1'b1;
  end

  assert_sclkIdleLow_R6: assert property (@(posedge clk) disable iff (!rstN)
    selN |-> !sclk);

  assert_sclkOnlyInFrame_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclk) |-> !selN);

  assert_sampleCount_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |-> (sampleCnt == lenQ));

  assert_noEarlySample_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !strb.sampleRx);

  assert_validPulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  assert_validAtDeselect_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selN) |-> (respValid && !busy));

  assert_busyIgnoresStart_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && start && !tick) |=> ($stable(periodIdx) && $stable(lenQ) && $stable(halfDivQ)));

endmodule

// File: rtl/cmdrsp_datapath.sv
module cmdrsp_datapath
  import cmdrsp_pkg::*;
#(
  parameter int CMD_W    = 8,
  parameter int RESP_MAX = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  input  logic [CMD_W-1:0]    cmdIn,
  input  logic                rxd,
  output logic                txd,
  output logic [RESP_MAX-1:0] respData
);
  localparam int TXC_W = $clog2(CMD_W + 2);

  logic [CMD_W-1:0]    cmdSh;
  logic                txdQ;
  logic [RESP_MAX-1:0] rxSh;
  logic [RESP_MAX-1:0] respQ;
  logic [TXC_W-1:0]    txBitCnt;  // bits placed on txd this frame (checker use)

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdSh    <= '0;
      txdQ     <= 1'b0;
      rxSh     <= '0;
      respQ    <= '0;
      txBitCnt <= '0;
    end else begin
      if (strb.load) begin
        // zero fill behind the command keeps txd low once it has been sent
        txdQ     <= cmdIn[CMD_W-1];
        cmdSh    <= cmdIn << 1;
        rxSh     <= '0;
        txBitCnt <= TXC_W'(1);
      end else if (strb.shiftTx) begin
        txdQ  <= cmdSh[CMD_W-1];
        cmdSh <= cmdSh << 1;
        if (txBitCnt <= TXC_W'(CMD_W)) txBitCnt <= txBitCnt + 1'b1;
      end
      if (strb.sampleRx) rxSh <= {rxSh[RESP_MAX-2:0], rxd};
      if (strb.finish) begin
        respQ <= rxSh;
        txdQ  <= 1'b0;
      end
    end
  end

  assign txd      = txdQ;
  assign respData = respQ;

  assert_txdLowAfterCmd_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txBitCnt > TXC_W'(CMD_W)) |-> !txd);

  assert_loadClearsRx_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (rxSh == '0));

endmodule

// File: rtl/cmdrsp_master.sv
module cmdrsp_master
  import cmdrsp_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int CMD_W    = 8,
  parameter int RESP_MIN = 4,
  parameter int RESP_MAX = 16,
  localparam int LEN_W   = $clog2(RESP_MAX + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [CMD_W-1:0]    cmdByte,
  input  logic [LEN_W-1:0]    respLen,
  input  logic [DIV_W-1:0]    divisor,
  output logic                busy,
  output logic [RESP_MAX-1:0] respData,
  output logic                respValid,
  output logic                sclk,
  output logic                selN,
  output logic                txd,
  input  logic                rxd
);
  ctrlStrobes_t strb;

  cmdrsp_ctrl #(
    .DIV_W(DIV_W), .CMD_W(CMD_W), .RESP_MIN(RESP_MIN),
    .RESP_MAX(RESP_MAX), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .respLen(respLen),
    .divisor(divisor), .busy(busy), .sclk(sclk), .selN(selN),
    .respValid(respValid), .strb(strb)
  );

  cmdrsp_datapath #(
    .CMD_W(CMD_W), .RESP_MAX(RESP_MAX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdIn(cmdByte),
    .rxd(rxd), .txd(txd), .respData(respData)
  );

  assert_selLowWhileBusy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> !selN);

endmodule

// File: tb/tb_cmdrsp_master.sv
module tb_cmdrsp_master;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 6;

  // {cmd[8], respLen[5], divisor[8], response[16]}
  localparam logic [36:0] VECS [0:NVEC-1] = '{
    {8'hA5, 5'd8,  8'd0, 16'h00C3},
    {8'h3C, 5'd4,  8'd1, 16'h000A},
    {8'hFF, 5'd16, 8'd2, 16'hBEEF},
    {8'h00, 5'd12, 8'd0, 16'h0A5F},
    {8'h81, 5'd5,  8'd3, 16'h0015},
    {8'h5A, 5'd16, 8'd0, 16'h8001}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [7:0]  cmdByte;
  logic [4:0]  respLen;
  logic [7:0]  divisor;
  logic        busy;
  logic [15:0] respData;
  logic        respValid;
  logic        sclk;
  logic        selN;
  logic        txd;
  logic        rxd;

  cmdrsp_master dut (
    .clk(clk), .rstN(rstN), .start(start), .cmdByte(cmdByte),
    .respLen(respLen), .divisor(divisor), .busy(busy),
    .respData(respData), .respValid(respValid), .sclk(sclk),
    .selN(selN), .txd(txd), .rxd(rxd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always @(posedge clk) cyc++;

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  // model slave
  int          fallCnt, riseCnt, txdBad, idleBad;
  int          lastRise, prevRise, selRise;
  logic [7:0]  cmdSeen;
  logic [15:0] slaveWord;
  int          slaveLen;

  initial begin
    rxd = 1'b1; fallCnt = 0; riseCnt = 0; txdBad = 0; idleBad = 0;
    lastRise = 0; prevRise = 0; selRise = 0; cmdSeen = '0;
    slaveWord = '0; slaveLen = 4;
  end

  always @(negedge selN) begin
    fallCnt = 0; riseCnt = 0; txdBad = 0; cmdSeen = '0;
    rxd = 1'b1;  // junk during the command phase
  end

  always @(negedge sclk) begin
    if (selN === 1'b0) begin
      fallCnt++;
      if (fallCnt >= 9 && fallCnt < 9 + slaveLen)
        rxd = slaveWord[slaveLen - 1 - (fallCnt - 9)];
      else
        rxd = 1'b1;  // junk in turnaround and after
    end
  end

  always @(posedge sclk) begin
    riseCnt++;
    prevRise = lastRise;
    lastRise = cyc;
    if (riseCnt <= 8) cmdSeen = {cmdSeen[6:0], txd};
    else if (txd !== 1'b0) txdBad++;
  end

  always @(posedge selN) selRise = cyc;

  always @(negedge clk) begin
    if (rstN === 1'b1 && selN === 1'b1 && sclk !== 1'b0) idleBad++;
    if (rstN === 1'b1 && selN === 1'b1 && txd !== 1'b0) idleBad++;
  end

  task automatic run_frame(input logic [7:0] cmd, input logic [4:0] len, input logic [7:0] dv,
                           input logic [15:0] resp, input int expLen, input bit interfere);
    int n;
    @(negedge clk);
    cmdByte = cmd; respLen = len; divisor = dv;
    slaveWord = resp; slaveLen = expLen;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R9 busy after start", busy, 1);
    if (interfere) begin
      repeat (20) @(negedge clk);
      cmdByte = 8'h11; respLen = 5'd16; divisor = 8'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (respValid !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(respValid === 1'b1, "R8 valid strobe", respValid, 1);
    chk(selN === 1'b1, "R8 selN high with valid", selN, 1);
    chk(busy === 1'b0, "R8 busy low with valid", busy, 0);
    chk(respData === resp, "R5 R3 R4 response data", respData, resp);
    chk(cmdSeen === cmd, "R2 command bits", cmdSeen, cmd);
    chk(riseCnt == 9 + expLen, "R5 rising edge count", riseCnt, 9 + expLen);
    chk(txdBad == 0, "R7 txd low after command", txdBad, 0);
    chk(lastRise - prevRise == 2 * (int'(dv) + 1), "R6 serial period", lastRise - prevRise, 2 * (int'(dv) + 1));
    chk(selRise - lastRise == 2 * (int'(dv) + 1), "R8 deselect delay", selRise - lastRise, 2 * (int'(dv) + 1));
    @(negedge clk);
    chk(respValid === 1'b0, "R8 valid one cycle", respValid, 0);
    chk(txd === 1'b0, "R7 txd idle", txd, 0);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; cmdByte = '0; respLen = 5'd4; divisor = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(selN === 1'b1, "R1 selN", selN, 1);
    chk(sclk === 1'b0, "R1 sclk", sclk, 0);
    chk(txd === 1'b0, "R1 txd", txd, 0);
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(respValid === 1'b0, "R1 respValid", respValid, 0);
    chk(respData === 16'h0, "R1 respData", respData, 0);

    for (int i = 0; i < NVEC; i++) begin
      run_frame(VECS[i][36:29], VECS[i][28:24], VECS[i][23:16], VECS[i][15:0],
                int'(VECS[i][28:24]), 1'b0);
    end

    // R5: length clamping
    run_frame(8'hC3, 5'd2, 8'd0, 16'h0009, 4, 1'b0);
    run_frame(8'h6E, 5'd20, 8'd1, 16'h1234, 16, 1'b0);

    // R10: start while busy ignored
    run_frame(8'h96, 5'd6, 8'd1, 16'h002D, 6, 1'b1);
    repeat (40) @(negedge clk);
    chk(busy === 1'b0 && selN === 1'b1, "R10 no extra frame", {busy, selN}, 2'b01);

    // R6: clock idle and txd low whenever deselected
    chk(idleBad == 0, "R6 R7 idle levels", idleBad, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule